// File: doc/BRIEF.md
# Secure Access Privilege Tracker

This block holds the security state of a zoned secure memory and, for every user zone, decides whether a read or a write may go ahead. It receives one-cycle result pulses from the password checker, the authentication engine, the encryption activation step and the per-command MAC checker. From those pulses it keeps track of the communication mode, of the single password currently in force and of the key set that last authenticated. The cipher, the MAC arithmetic and the configuration store live outside the block. Their results arrive as pulses and their settings as a packed configuration vector.

Each password set and each key set has a saturating attempt counter. Once a counter has reached the trial limit, every later attempt on that set is treated as a failure, whatever the checker reports. A card-level reset input withdraws every privilege but keeps the counters. Only the synchronous block reset clears the counters.

Top module: `sec_priv_tracker`

## Requirements
- R1: After `rst` the mode is standard (`mode` = 0), no password is active, no key is authenticated and all attempt counters are zero. A zone whose configuration demands nothing is granted both read and write.
- R2: A counted authentication success on key set k (`au_evt`=1, `au_ok`=1, counter of k below the limit) sets the mode to authenticated (`mode` = 1) and memorises k, replacing any earlier key. It also leaves encryption mode.
- R3: An authentication attempt that fails, for any reason, returns the mode to standard and drops the authentication held before it.
- R4: `enc_act` moves the mode from authenticated to encrypted (`mode` = 2) only if `enc_idx` equals the memorised key. In any other case it is ignored.
- R5: A MAC mismatch (`mac_evt`=1, `mac_ok`=0) in authenticated or encrypted mode returns the mode to standard. A matching MAC, or a mismatch in standard mode, changes nothing.
- R6: At most one password is active at a time. A counted success on set p makes p the active password and records whether it is a write password (`pw_wr`=1). Any failed password attempt leaves no password active.
- R7: An active write password grants read and write to the zones that select its set. An active read password grants read only.
- R8: A failed attempt raises that set's counter by one, saturating at `trial_limit`. A success clears it. While the counter is at or above the limit, an attempt fails even when the checker reports a pass.
- R9: `sec_rst` withdraws the password and the authentication and forces standard mode. Attempt counters keep their values. It overrides every other event in the same cycle, and an attempt made in that cycle is not counted.
- R10: Each zone has an 8-bit field in `zone_cfg` at bits [8z+7:8z]: [2:0] password set, [3] password required, [5:4] key set, [6] authentication required, [7] encryption required. Read is granted when every requirement is met. A required password is met by the selected set being active. A required authentication is met by mode 1 or 2 with the selected key memorised. A required encryption is met by mode 2 with the selected key. Write is granted on the same terms, except that the password must also be a write password.
- R11: Within one cycle, an authentication event takes precedence over `enc_act`, and `enc_act` takes precedence over a MAC result. Password events are processed alongside these.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| sec_rst | input | 1 | Card reset: withdraws privileges |
| pw_evt | input | 1 | Password check result pulse |
| pw_ok | input | 1 | Checker reported a match |
| pw_wr | input | 1 | Presented password is a write password |
| pw_idx | input | 3 | Password set index |
| au_evt | input | 1 | Authentication result pulse |
| au_ok | input | 1 | Authentication reported success |
| au_idx | input | 2 | Key set index |
| enc_act | input | 1 | Encryption activation pulse |
| enc_idx | input | 2 | Key set used for activation |
| mac_evt | input | 1 | MAC check result pulse |
| mac_ok | input | 1 | MAC matched |
| trial_limit | input | 4 | Attempt limit per set |
| zone_cfg | input | 32 | Packed per-zone configuration |
| mode | output | 2 | 0 standard, 1 authenticated, 2 encrypted |
| rd_grant | output | 4 | Per-zone read permission |
| wr_grant | output | 4 | Per-zone write permission |

## Verification
On every cycle, the assertions check the following: how the attempt counters move on success and on failure, that encryption is entered only from the authenticated mode, that a MAC mismatch or a card reset leaves the block in standard mode, and that a zone demanding encryption is never granted outside mode 2. Other behaviour depends on the order of past events, and only the bench's scenarios can show it. That covers password replacement, the loss of an earlier authentication after a failed attempt, lockout forcing a reported pass to fail, and counters surviving a card reset. The bench compares the mode and both grant vectors after every event against its own model.

// File: rtl/sec_priv_pkg.sv
package sec_priv_pkg;
    parameter int PW_SETS   = 8;
    parameter int KEY_SETS  = 4;
    localparam int PW_IDX_W  = $clog2(PW_SETS);
    localparam int KEY_IDX_W = $clog2(KEY_SETS);

    typedef enum logic [1:0] {
        MODE_STD  = 2'd0,
        MODE_AUTH = 2'd1,
        MODE_ENC  = 2'd2
    } sec_mode_e;

    typedef struct packed {
        logic                 need_enc;
        logic                 need_auth;
        logic [KEY_IDX_W-1:0] key_sel;
        logic                 need_pw;
        logic [PW_IDX_W-1:0]  pw_sel;
    } zone_cfg_t;

    localparam int ZCFG_W = $bits(zone_cfg_t);

    typedef struct packed {
        sec_mode_e            mode;
        logic                 pw_valid;
        logic                 pw_write;
        logic [PW_IDX_W-1:0]  pw_idx;
        logic [KEY_IDX_W-1:0] au_key;
    } priv_state_t;

    function automatic logic key_holds(priv_state_t st, logic [KEY_IDX_W-1:0] k, logic need_enc_mode);
        if (need_enc_mode)
            return (st.mode == MODE_ENC) && (st.au_key == k);
        return (st.mode != MODE_STD) && (st.au_key == k);
    endfunction
endpackage

// File: rtl/sp_try_counter.sv
module sp_try_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit,
    input  logic             claim_ok,
    input  logic [CNT_W-1:0] limit,
    output logic             pass
);
    logic [CNT_W-1:0] cnt_q;
    logic             locked;

    assign locked = (cnt_q >= limit);
    assign pass   = hit && claim_ok && !locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (hit) begin
            if (pass)
                cnt_q <= '0;
            else if (cnt_q < limit)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_success_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && pass) |=> (cnt_q == '0));

    assert_fail_counts_R8: assert property (@(posedge clk) disable iff (rst)
        (hit && !claim_ok && (cnt_q < limit)) |=> (cnt_q == $past(cnt_q) + 1'b1));

    assert_idle_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(cnt_q));
endmodule

// File: rtl/sp_zone_gate.sv
module sp_zone_gate
    import sec_priv_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  zone_cfg_t   cfg,
    input  priv_state_t st,
    output logic        rd,
    output logic        wr
);
    logic pw_rd_ok, pw_wr_ok, au_ok, en_ok;

    always_comb begin
        pw_rd_ok = !cfg.need_pw || (st.pw_valid && (st.pw_idx == cfg.pw_sel));
        pw_wr_ok = !cfg.need_pw || (st.pw_valid && st.pw_write && (st.pw_idx == cfg.pw_sel));
        au_ok    = !cfg.need_auth || key_holds(st, cfg.key_sel, 1'b0);
        en_ok    = !cfg.need_enc  || key_holds(st, cfg.key_sel, 1'b1);
        rd       = pw_rd_ok && au_ok && en_ok;
        wr       = pw_wr_ok && au_ok && en_ok;
    end

    assert_enc_zone_needs_enc_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg.need_enc && (rd || wr)) |-> (st.mode == MODE_ENC));

    assert_write_implies_read_R7: assert property (@(posedge clk) disable iff (rst)
        wr |-> rd);
endmodule

// File: rtl/sec_priv_tracker.sv
module sec_priv_tracker
    import sec_priv_pkg::*;
#(
    parameter int NUM_ZONES = 4,
    parameter int CNT_W     = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sec_rst,
    input  logic                        pw_evt,
    input  logic                        pw_ok,
    input  logic                        pw_wr,
    input  logic [PW_IDX_W-1:0]         pw_idx,
    input  logic                        au_evt,
    input  logic                        au_ok,
    input  logic [KEY_IDX_W-1:0]        au_idx,
    input  logic                        enc_act,
    input  logic [KEY_IDX_W-1:0]        enc_idx,
    input  logic                        mac_evt,
    input  logic                        mac_ok,
    input  logic [CNT_W-1:0]            trial_limit,
    input  logic [NUM_ZONES*ZCFG_W-1:0] zone_cfg,
    output logic [1:0]                  mode,
    output logic [NUM_ZONES-1:0]        rd_grant,
    output logic [NUM_ZONES-1:0]        wr_grant
);
    priv_state_t         st_q;
    logic [PW_SETS-1:0]  pw_pass;
    logic [KEY_SETS-1:0] au_pass;
    logic                pw_live, au_live;

    assign pw_live = pw_evt && !sec_rst;
    assign au_live = au_evt && !sec_rst;

    generate
        for (genvar p = 0; p < PW_SETS; p++) begin : g_pw_cnt
            sp_try_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .hit      (pw_live && (pw_idx == PW_IDX_W'(p))),
                .claim_ok (pw_ok),
                .limit    (trial_limit),
                .pass     (pw_pass[p])
            );
        end
        for (genvar k = 0; k < KEY_SETS; k++) begin : g_key_cnt
            sp_try_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk      (clk),
                .rst      (rst),
                .hit      (au_live && (au_idx == KEY_IDX_W'(k))),
                .claim_ok (au_ok),
                .limit    (trial_limit),
                .pass     (au_pass[k])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || sec_rst) begin
            st_q <= '{mode: MODE_STD, pw_valid: 1'b0, pw_write: 1'b0,
                      pw_idx: '0, au_key: '0};
        end else begin
            if (pw_evt) begin
                st_q.pw_valid <= |pw_pass;
                if (|pw_pass) begin
                    st_q.pw_idx   <= pw_idx;
                    st_q.pw_write <= pw_wr;
                end
            end
            if (au_evt) begin
                if (|au_pass) begin
                    st_q.mode   <= MODE_AUTH;
                    st_q.au_key <= au_idx;
                end else begin
                    st_q.mode   <= MODE_STD;
                end
            end else if (enc_act && (st_q.mode == MODE_AUTH) && (enc_idx == st_q.au_key)) begin
                st_q.mode <= MODE_ENC;
            end else if (mac_evt && !mac_ok) begin
                st_q.mode <= MODE_STD;
            end
        end
    end

    assign mode = st_q.mode;

    generate
        for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
            sp_zone_gate u_gate (
                .clk (clk),
                .rst (rst),
                .cfg (zone_cfg_t'(zone_cfg[z*ZCFG_W +: ZCFG_W])),
                .st  (st_q),
                .rd  (rd_grant[z]),
                .wr  (wr_grant[z])
            );
        end
    endgenerate

    assert_enc_from_auth_R4: assert property (@(posedge clk) disable iff (rst)
        ((st_q.mode == MODE_ENC) && ($past(st_q.mode) != MODE_ENC)) |-> ($past(st_q.mode) == MODE_AUTH));

    assert_mac_revokes_R5: assert property (@(posedge clk) disable iff (rst)
        (mac_evt && !mac_ok && !au_evt && !enc_act) |=> (st_q.mode == MODE_STD));

    assert_card_reset_R9: assert property (@(posedge clk) disable iff (rst)
        sec_rst |=> ((st_q.mode == MODE_STD) && !st_q.pw_valid));

    assert_auth_fail_drops_R3: assert property (@(posedge clk) disable iff (rst)
        (au_evt && !au_ok) |=> (st_q.mode == MODE_STD));

    assert_one_pass_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pw_pass) && $onehot0(au_pass));
endmodule

// File: tb/sim_sec_priv_tracker.sv
module sim_sec_priv_tracker;
    logic clk = 0, rst = 1, sec_rst = 0;
    logic pw_evt = 0, pw_ok = 0, pw_wr = 0;
    logic [2:0] pw_idx = 0;
    logic au_evt = 0, au_ok = 0;
    logic [1:0] au_idx = 0;
    logic enc_act = 0;
    logic [1:0] enc_idx = 0;
    logic mac_evt = 0, mac_ok = 0;
    logic [3:0] trial_limit = 4'd3;
    logic [31:0] zone_cfg = 0;
    logic [1:0] mode;
    logic [3:0] rd_grant, wr_grant;

    int n_vec = 0, n_bad = 0;

    // bench model of the requirements
    int m_mode; bit m_pwv, m_pww; int m_pwi, m_key;
    int m_pcnt[8]; int m_kcnt[4];

    always #5 clk = ~clk;

    sec_priv_tracker u0 (.*);

    function automatic bit exp_rd(int z, bit wrq);
        bit [7:0] c = zone_cfg[z*8 +: 8];
        bit ok = 1;
        if (c[3]) ok &= m_pwv && (m_pwi == int'(c[2:0])) && (!wrq || m_pww);
        if (c[6]) ok &= (m_mode != 0) && (m_key == int'(c[5:4]));
        if (c[7]) ok &= (m_mode == 2) && (m_key == int'(c[5:4]));
        return ok;
    endfunction

    task automatic check(string tag);
        logic [3:0] er, ew;
        for (int z = 0; z < 4; z++) begin
            er[z] = exp_rd(z, 0);
            ew[z] = exp_rd(z, 1);
        end
        n_vec++;
        if (mode !== 2'(m_mode) || rd_grant !== er || wr_grant !== ew) begin
            n_bad++;
            $display("FAIL %s: mode/rd/wr actual %0d/%b/%b expected %0d/%b/%b",
                     tag, mode, rd_grant, wr_grant, m_mode, er, ew);
        end
    endtask

    // op: 0 pw, 1 auth, 2 enc, 3 mac, 4 card reset, 5 idle, 6 card reset with auth
    task automatic apply(int op, bit ok, int idx, bit wrf, string tag);
        int lim = int'(trial_limit);
        sec_rst = (op == 4 || op == 6);
        pw_evt = (op == 0); pw_ok = ok; pw_wr = wrf; pw_idx = 3'(idx);
        au_evt = (op == 1 || op == 6); au_ok = ok; au_idx = 2'(idx);
        enc_act = (op == 2); enc_idx = 2'(idx);
        mac_evt = (op == 3); mac_ok = ok;
        @(posedge clk);
        if (sec_rst) begin
            m_mode = 0; m_pwv = 0; m_pww = 0; m_pwi = 0; m_key = 0;
        end else if (op == 0) begin
            if (ok && m_pcnt[idx] < lim) begin
                m_pcnt[idx] = 0; m_pwv = 1; m_pwi = idx; m_pww = wrf;
            end else begin
                if (m_pcnt[idx] < lim) m_pcnt[idx]++;
                m_pwv = 0;
            end
        end else if (op == 1) begin
            if (ok && m_kcnt[idx] < lim) begin
                m_kcnt[idx] = 0; m_mode = 1; m_key = idx;
            end else begin
                if (m_kcnt[idx] < lim) m_kcnt[idx]++;
                m_mode = 0;
            end
        end else if (op == 2) begin
            if (m_mode == 1 && idx == m_key) m_mode = 2;
        end else if (op == 3) begin
            if (!ok) m_mode = 0;
        end
        @(negedge clk);
        check(tag);
        sec_rst = 0; pw_evt = 0; au_evt = 0; enc_act = 0; mac_evt = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EC0_0042));
        m_mode = 0; m_pwv = 0; m_pww = 0; m_pwi = 0; m_key = 0;
        foreach (m_pcnt[i]) m_pcnt[i] = 0;
        foreach (m_kcnt[i]) m_kcnt[i] = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 reset, empty config");
        // zone0 write pw set5, zone1 auth key2, zone2 enc key2, zone3 read pw set1 + auth key1
        zone_cfg = {8'b0101_1001, 8'b1010_0000, 8'b0110_0000, 8'b0000_1101};
        #1 check("R1 reset, demanding config");
        apply(1, 1, 2, 0, "R2 auth pass key2");
        apply(2, 1, 1, 0, "R4 enc wrong key ignored");
        apply(2, 1, 2, 0, "R4 enc activation");
        apply(1, 1, 2, 0, "R2 reauth leaves enc");
        apply(2, 1, 2, 0, "R4 enc again");
        apply(3, 1, 0, 0, "R5 mac match no effect");
        apply(3, 0, 0, 0, "R5 mac mismatch revokes");
        apply(3, 0, 0, 0, "R5 mismatch in standard");
        apply(2, 1, 2, 0, "R4 enc from standard ignored");
        apply(1, 1, 1, 0, "R2 auth key1");
        apply(1, 0, 1, 0, "R3 failed reauth drops");
        apply(0, 1, 5, 1, "R7 write pw set5");
        apply(0, 1, 1, 0, "R6 read pw set1 replaces");
        apply(1, 1, 1, 0, "R7 read pw with auth");
        apply(0, 0, 1, 0, "R6 failed pw clears");
        apply(0, 1, 5, 0, "R7 read pw set5 no write");
        apply(1, 1, 2, 0, "R11 auth before enc");
        sec_rst = 0;
        // same cycle: auth beats enc and mac
        au_evt = 1; au_ok = 0; au_idx = 2; enc_act = 1; enc_idx = 2; mac_evt = 1; mac_ok = 0;
        @(posedge clk);
        m_kcnt[2]++; m_mode = 0;
        @(negedge clk);
        check("R11 auth fail wins over enc");
        au_evt = 0; enc_act = 0; mac_evt = 0;
        apply(1, 1, 2, 0, "R11 auth");
        enc_act = 1; enc_idx = 2; mac_evt = 1; mac_ok = 0;
        @(posedge clk);
        m_mode = 2;
        @(negedge clk);
        check("R11 enc wins over mac");
        enc_act = 0; mac_evt = 0;
        // lockout on key3 with limit 2
        trial_limit = 4'd2;
        apply(1, 0, 3, 0, "R8 fail one");
        apply(1, 0, 3, 0, "R8 fail two");
        apply(1, 1, 3, 0, "R8 locked pass forced fail");
        apply(6, 1, 3, 0, "R9 card reset beats auth");
        apply(1, 1, 3, 0, "R9 counters survive card reset");
        trial_limit = 4'd4;
        apply(1, 1, 3, 0, "R8 limit raised pass clears");
        apply(1, 0, 3, 0, "R8 count after clear");
        apply(0, 1, 2, 1, "R6 pw set2");
        apply(4, 0, 0, 0, "R9 card reset clears");
        for (int i = 0; i < 1500; i++) begin
            int op;
            if (i % 50 == 0) begin
                zone_cfg = $urandom;
                trial_limit = 4'($urandom_range(1, 5));
            end
            op = $urandom_range(0, 6);
            if (op == 4 && ($urandom % 4) != 0) op = 5;
            apply(op, ($urandom % 3) != 0, (op == 0) ? $urandom_range(0, 7) : $urandom_range(0, 3),
                  1'($urandom), (op == 0) ? "R6 R7 R10 random pw" :
                  (op == 1) ? "R2 R3 R8 random auth" : (op == 2) ? "R4 random enc" :
                  (op == 3) ? "R5 random mac" : "R9 R10 random other");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule